// File: doc/BRIEF.md
# Reservation Monitor for Linked Load / Conditional Store

This block sits next to a memory port and decides, for every store that passes through, whether the store may write. It keeps a small table of address reservations. A load-linked request from an execution context creates a reservation. An execution context is one CPU number together with one thread number. A later store-conditional from the same context to the same 16-byte granule succeeds only while that reservation is still present. Every store clears the reservations that cover its granule, whether the store is plain or conditional, and whether it succeeds or fails.

Requests arrive on a valid-qualified stream. The monitor never applies back-pressure, so it takes one request on every cycle in which `req_valid` is high. For that reason it has no ready output, and an upstream stage may treat it as always ready. The decision is combinational: `wr_en` and `sc_result` belong to the request presented in the same cycle. The table changes at the following rising clock edge.

A load-linked request from a context that already owns an entry reuses that entry, and the entry becomes the newest. When the table is full and the requesting context owns no entry, the entry whose last load-linked is the oldest is evicted. Reservations never expire in any other way.

Top module: `llsc_resv_monitor`

## Requirements
- R1: Addresses are compared at 16-byte granularity: two addresses that differ only in bits [3:0] refer to the same reservation.
- R2: A valid load-linked request (`req_kind` = 2'b01) records a reservation holding the granule address, the CPU number and the thread number of the requester.
- R3: A reservation belongs to a requester only when both its CPU number and its thread number are equal to the requester's. A store-conditional from a different CPU or a different thread fails.
- R4: Every valid store, either plain (`req_kind` = 2'b10) or conditional (`req_kind` = 2'b11), clears all reservations for its granule. This includes a failed store-conditional.
- R5: A store-conditional that is presented while the table holds no reservation gives `wr_en`=0 and `sc_result`=0.
- R6: A plain store always gives `wr_en`=1 and `sc_result`=0, whatever the table holds.
- R7: A store-conditional that matches a reservation on both granule and context gives `wr_en`=1 and `sc_result`=1. Any other store-conditional gives 0 and 0. A successful store-conditional also removes every reservation for that granule, including the reservations of other contexts.
- R8: A load-linked request from a context that already owns a reservation replaces that reservation. The previous granule is no longer reserved for that context.
- R9: When all NENT entries are valid and the requesting context owns none of them, a load-linked request evicts the entry whose last load-linked is the oldest. Entries freed by stores are reused before any eviction.
- R10: `wr_en` and `sc_result` are valid in the cycle of the request. The table updates only at the next rising edge of `clk`.
- R11: A synchronous reset (`rst` high at a rising edge) invalidates every reservation.
- R12: A plain load (`req_kind` = 2'b00), or any cycle with `req_valid` low, leaves the table unchanged and drives `wr_en`=0 and `sc_result`=0. A load-linked request also drives both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Qualifies the request fields in this cycle |
| req_kind | input | 2 | 00 load, 01 load-linked, 10 store, 11 store-conditional |
| req_addr | input | AW | Byte address of the request |
| req_cpu | input | CPUW | CPU number of the requester |
| req_tid | input | TIDW | Thread number within that CPU |
| wr_en | output | 1 | The store in this cycle may write memory |
| sc_result | output | 1 | Result code of a store-conditional: 1 success, 0 failure |

## Verification
The assertions assume that `rst` is held high from time zero until at least one rising edge. They also assume that the request fields carry known values on every cycle after reset, even while `req_valid` is low. The bench drives every input from time zero and keeps reset high for several cycles. The rank assertions rely on one property of the stimulus: each context holds at most one entry. R8 guarantees this for any legal sequence of requests, so the bench applies no further restriction.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    KIND_LOAD  = 2'b00,
    KIND_LINK  = 2'b01,
    KIND_STORE = 2'b10,
    KIND_COND  = 2'b11
  } req_kind_e;
endpackage

// File: rtl/llsc_slot.sv
// One reservation entry: granule tag, owning context, age rank.
module llsc_slot #(
  parameter int TAGW  = 28,
  parameter int CPUW  = 2,
  parameter int TIDW  = 2,
  parameter int RANKW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAGW-1:0]  key_tag,
  input  logic [CPUW-1:0]  key_cpu,
  input  logic [TIDW-1:0]  key_tid,
  input  logic             set_i,
  input  logic             kill_i,
  input  logic [RANKW-1:0] rank_d,
  output logic             vld_o,
  output logic             addr_hit_o,
  output logic             ctx_hit_o,
  output logic [RANKW-1:0] rank_o
);
  logic [TAGW-1:0] tag_q;
  logic [CPUW-1:0] cpu_q;
  logic [TIDW-1:0] tid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      rank_o <= '0;
      tag_q  <= '0;
      cpu_q  <= '0;
      tid_q  <= '0;
    end else begin
      if (set_i) begin
        vld_o <= 1'b1;
        tag_q <= key_tag;
        cpu_q <= key_cpu;
        tid_q <= key_tid;
      end else if (kill_i) begin
        vld_o <= 1'b0;
      end
      rank_o <= rank_d;
    end
  end

  assign addr_hit_o = vld_o && (tag_q == key_tag);
  assign ctx_hit_o  = vld_o && (cpu_q == key_cpu) && (tid_q == key_tid);

  AST_SLOT_RECORDS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> (vld_o && tag_q == $past(key_tag) && cpu_q == $past(key_cpu)
               && tid_q == $past(key_tid) && rank_o == '0)); // R2
endmodule

// File: rtl/llsc_pick.sv
// Chooses the entry a load-linked writes: own entry, else lowest free, else oldest.
module llsc_pick #(
  parameter int NENT  = 8,
  parameter int RANKW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NENT-1:0]  vld,
  input  logic [NENT-1:0]  own,
  input  logic [RANKW-1:0] rank [NENT],
  output logic [NENT-1:0]  pick
);
  localparam logic [RANKW-1:0] OLDEST = RANKW'(NENT - 1);

  always_comb begin
    logic done;
    pick = '0;
    done = 1'b0;
    for (int i = 0; i < NENT; i++) begin
      if (!done && own[i]) begin
        pick[i] = 1'b1;
        done    = 1'b1;
      end
    end
    for (int i = 0; i < NENT; i++) begin
      if (!done && !vld[i]) begin
        pick[i] = 1'b1;
        done    = 1'b1;
      end
    end
    for (int i = 0; i < NENT; i++) begin
      if (!done && vld[i] && rank[i] == OLDEST) begin
        pick[i] = 1'b1;
        done    = 1'b1;
      end
    end
  end

  AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot(pick)); // R9
  AST_OWN_REUSED: assert property (@(posedge clk) disable iff (rst)
    (own != '0) |-> ((pick & own) != '0)); // R8
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor #(
  parameter int AW         = 32,
  parameter int CPUW       = 2,
  parameter int TIDW       = 2,
  parameter int NENT       = 8,
  parameter int GRAN_BYTES = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic [AW-1:0]   req_addr,
  input  logic [CPUW-1:0] req_cpu,
  input  logic [TIDW-1:0] req_tid,
  output logic            wr_en,
  output logic            sc_result
);
  import llsc_pkg::*;

  localparam int GRANB = $clog2(GRAN_BYTES);
  localparam int TAGW  = AW - GRANB;
  localparam int RANKW = (NENT > 1) ? $clog2(NENT) : 1;

  logic [TAGW-1:0]  key_tag;
  logic             is_ll, is_st, is_sc, any_store, own_hit;
  logic [NENT-1:0]  vld, ahit, chit, pick, set_v, kill_v, young;
  logic [RANKW-1:0] rank_q [NENT];
  logic [RANKW-1:0] rank_d [NENT];
  logic [RANKW-1:0] pick_rank;
  logic             pick_vld;

  assign key_tag   = req_addr[AW-1:GRANB];
  assign is_ll     = req_valid && (req_kind == KIND_LINK);
  assign is_st     = req_valid && (req_kind == KIND_STORE);
  assign is_sc     = req_valid && (req_kind == KIND_COND);
  assign any_store = is_st || is_sc;
  assign own_hit   = |(ahit & chit);

  assign wr_en     = is_st || (is_sc && own_hit);
  assign sc_result = is_sc && own_hit;

  assign set_v  = is_ll ? pick : '0;
  assign kill_v = any_store ? ahit : '0;

  llsc_pick #(.NENT(NENT), .RANKW(RANKW)) u_pick (
    .clk(clk), .rst(rst), .vld(vld), .own(chit), .rank(rank_q), .pick(pick)
  );

  always_comb begin
    pick_rank = '0;
    for (int j = 0; j < NENT; j++) begin
      if (pick[j]) pick_rank = pick_rank | rank_q[j];
    end
  end
  assign pick_vld = |(pick & vld);

  for (genvar i = 0; i < NENT; i++) begin : g_slot
    always_comb begin
      logic [RANKW:0] older_gone;
      older_gone = '0;
      for (int j = 0; j < NENT; j++) begin
        if (kill_v[j] && rank_q[j] < rank_q[i]) older_gone = older_gone + (RANKW+1)'(1);
      end
      rank_d[i] = rank_q[i];
      if (is_ll) begin
        if (set_v[i]) rank_d[i] = '0;
        else if (vld[i] && (!pick_vld || rank_q[i] < pick_rank))
          rank_d[i] = rank_q[i] + RANKW'(1);
      end else if (any_store) begin
        rank_d[i] = rank_q[i] - older_gone[RANKW-1:0];
      end
    end

    llsc_slot #(.TAGW(TAGW), .CPUW(CPUW), .TIDW(TIDW), .RANKW(RANKW)) u_slot (
      .clk(clk), .rst(rst), .key_tag(key_tag), .key_cpu(req_cpu), .key_tid(req_tid),
      .set_i(set_v[i]), .kill_i(kill_v[i]), .rank_d(rank_d[i]),
      .vld_o(vld[i]), .addr_hit_o(ahit[i]), .ctx_hit_o(chit[i]), .rank_o(rank_q[i])
    );

    assign young[i] = vld[i] && (rank_q[i] == '0);

    AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (any_store && ahit[i]) |=> !vld[i]); // R4
  end

  AST_SC_EMPTY_FAILS: assert property (@(posedge clk) disable iff (rst)
    (is_sc && vld == '0) |-> (!wr_en && !sc_result)); // R5
  AST_PLAIN_STORE_WRITES: assert property (@(posedge clk) disable iff (rst)
    is_st |-> (wr_en && !sc_result)); // R6
  AST_SUCCESS_WRITES: assert property (@(posedge clk) disable iff (rst)
    sc_result |-> (wr_en && is_sc && vld != '0)); // R7
  AST_IDLE_KEEPS_TABLE: assert property (@(posedge clk) disable iff (rst)
    (!req_valid || req_kind == KIND_LOAD) |=> $stable(vld)); // R12
  AST_LOADS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!req_valid || req_kind == KIND_LOAD || req_kind == KIND_LINK) |-> (!wr_en && !sc_result)); // R12
  AST_ONE_NEWEST: assert property (@(posedge clk) disable iff (rst)
    $onehot0(young)); // R9
  AST_RESET_EMPTIES: assert property (@(posedge clk)
    $past(rst) |-> (vld == '0)); // R11
endmodule

// File: tb/tb_llsc_resv_monitor.sv
`timescale 1ns/1ps
module tb_llsc_resv_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_cpu = '0;
  logic [1:0]  req_tid = '0;
  logic        wr_en, sc_result;
  int          nchk = 0;
  int          nerr = 0;
  bit          done = 1'b0;

  localparam logic [1:0] LD = 2'b00, LL = 2'b01, ST = 2'b10, SC = 2'b11;

  always #2.5 clk = ~clk;

  llsc_resv_monitor dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_cpu(req_cpu), .req_tid(req_tid),
    .wr_en(wr_en), .sc_result(sc_result)
  );

  typedef struct packed {
    logic [1:0]  k;
    logic [31:0] a;
    logic [1:0]  c;
    logic [1:0]  t;
    logic        we;
    logic        res;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{SC, 32'h100, 2'd0, 2'd0, 1'b0, 1'b0, 4'd5},  // R5 empty table
    '{ST, 32'h100, 2'd0, 2'd0, 1'b1, 1'b0, 4'd6},  // R6 empty table
    '{LL, 32'h100, 2'd0, 2'd0, 1'b0, 1'b0, 4'd2},  // R2
    '{SC, 32'h10C, 2'd0, 2'd0, 1'b1, 1'b1, 4'd1},  // R1 low bits ignored
    '{SC, 32'h100, 2'd0, 2'd0, 1'b0, 1'b0, 4'd7},  // R7 own entry consumed
    '{LL, 32'h200, 2'd1, 2'd2, 1'b0, 1'b0, 4'd2},
    '{SC, 32'h200, 2'd1, 2'd3, 1'b0, 1'b0, 4'd3},  // R3 thread differs
    '{SC, 32'h200, 2'd1, 2'd2, 1'b0, 1'b0, 4'd4},  // R4 failed SC cleared it
    '{LL, 32'h300, 2'd2, 2'd1, 1'b0, 1'b0, 4'd2},
    '{LD, 32'h300, 2'd3, 2'd3, 1'b0, 1'b0, 4'd12}, // R12 load
    '{SC, 32'h30F, 2'd2, 2'd1, 1'b1, 1'b1, 4'd7},
    '{LL, 32'h400, 2'd0, 2'd0, 1'b0, 1'b0, 4'd2},
    '{LL, 32'h400, 2'd1, 2'd1, 1'b0, 1'b0, 4'd2},
    '{ST, 32'h408, 2'd3, 2'd0, 1'b1, 1'b0, 4'd6},
    '{SC, 32'h400, 2'd0, 2'd0, 1'b0, 1'b0, 4'd4},  // R4 plain store cleared
    '{SC, 32'h400, 2'd1, 2'd1, 1'b0, 1'b0, 4'd4},
    '{LL, 32'h500, 2'd0, 2'd1, 1'b0, 1'b0, 4'd2},
    '{LL, 32'h500, 2'd2, 2'd2, 1'b0, 1'b0, 4'd2},
    '{SC, 32'h500, 2'd2, 2'd2, 1'b1, 1'b1, 4'd7},
    '{SC, 32'h500, 2'd0, 2'd1, 1'b0, 1'b0, 4'd7},  // R7 other context removed
    '{LL, 32'h600, 2'd3, 2'd3, 1'b0, 1'b0, 4'd2},
    '{LL, 32'h700, 2'd3, 2'd3, 1'b0, 1'b0, 4'd8},  // R8 overwrite
    '{SC, 32'h600, 2'd3, 2'd3, 1'b0, 1'b0, 4'd8},
    '{SC, 32'h700, 2'd3, 2'd3, 1'b1, 1'b1, 4'd8},
    '{LL, 32'h800, 2'd1, 2'd0, 1'b0, 1'b0, 4'd2},
    '{SC, 32'h800, 2'd0, 2'd0, 1'b0, 1'b0, 4'd3}   // R3 cpu differs
  };

  task automatic chk(input string tag, input logic we, input logic res);
    nchk++;
    if (wr_en !== we || sc_result !== res) begin
      nerr++;
      $display("FAIL %s: wr_en=%b sc_result=%b expected wr_en=%b sc_result=%b",
               tag, wr_en, sc_result, we, res);
    end
  endtask

  // drive at the falling edge, sample 1 ns later, well before the rising edge
  task automatic req(input logic v, input logic [1:0] k, input logic [31:0] a,
                     input int c, input int t, input logic we, input logic res,
                     input string tag);
    @(negedge clk);
    req_valid = v; req_kind = k; req_addr = a;
    req_cpu = 2'(c); req_tid = 2'(t);
    #1;
    chk(tag, we, res);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic fill8();
    for (int k = 0; k < 8; k++)
      req(1'b1, LL, 32'h1000 + 32'(k * 16), k / 4, k % 4, 1'b0, 1'b0, "R9 fill");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R11 reset idle outputs", 1'b0, 1'b0);
    req(1'b1, SC, 32'h40, 0, 0, 1'b0, 1'b0, "R11 empty after reset");

    for (int i = 0; i < NV; i++)
      req(1'b1, VECS[i].k, VECS[i].a, int'(VECS[i].c), int'(VECS[i].t),
          VECS[i].we, VECS[i].res, $sformatf("R%0d vector %0d", VECS[i].req, i));

    // R12: invalid cycle carrying a store must not touch the reservation
    req(1'b1, LL, 32'hA00, 1, 1, 1'b0, 1'b0, "R12 setup");
    req(1'b0, ST, 32'hA00, 2, 2, 1'b0, 1'b0, "R12 valid low outputs");
    req(1'b1, SC, 32'hA04, 1, 1, 1'b1, 1'b1, "R12 reservation kept");

    // R10: outputs in same cycle, table updates only at the edge
    @(negedge clk);
    req_valid = 1'b1; req_kind = LL; req_addr = 32'hB00; req_cpu = 2'd2; req_tid = 2'd0;
    #0.5;
    chk("R10 link output", 1'b0, 1'b0);
    req_kind = SC;
    #0.5;
    chk("R10 not yet updated", 1'b0, 1'b0);
    req(1'b1, LL, 32'hB00, 2, 0, 1'b0, 1'b0, "R10 link");
    req(1'b1, SC, 32'hB00, 2, 0, 1'b1, 1'b1, "R10 updated after edge");

    // R11: reset drops a live reservation
    req(1'b1, LL, 32'hC00, 3, 1, 1'b0, 1'b0, "R11 setup");
    do_reset();
    req(1'b1, SC, 32'hC00, 3, 1, 1'b0, 1'b0, "R11 reservation gone");

    // R9: full table evicts oldest
    do_reset();
    fill8();
    req(1'b1, LL, 32'h2000, 2, 0, 1'b0, 1'b0, "R9 evicting link");
    req(1'b1, SC, 32'h1000, 0, 0, 1'b0, 1'b0, "R9 oldest evicted");
    req(1'b1, SC, 32'h1010, 0, 1, 1'b1, 1'b1, "R9 second kept");
    req(1'b1, SC, 32'h2000, 2, 0, 1'b1, 1'b1, "R9 new entry present");

    // R8 + R9: refreshed owner becomes newest
    do_reset();
    fill8();
    req(1'b1, LL, 32'h1000, 0, 0, 1'b0, 1'b0, "R8 refresh");
    req(1'b1, LL, 32'h2000, 2, 0, 1'b0, 1'b0, "R9 evicting link");
    req(1'b1, SC, 32'h1000, 0, 0, 1'b1, 1'b1, "R8 refreshed kept");
    req(1'b1, SC, 32'h1010, 0, 1, 1'b0, 1'b0, "R9 next oldest evicted");

    // R9: freed entry reused before eviction
    do_reset();
    fill8();
    req(1'b1, SC, 32'h1030, 0, 3, 1'b1, 1'b1, "R9 free one");
    req(1'b1, LL, 32'h2000, 2, 0, 1'b0, 1'b0, "R9 fill hole");
    req(1'b1, LL, 32'h2010, 2, 1, 1'b0, 1'b0, "R9 evicting link");
    req(1'b1, SC, 32'h1000, 0, 0, 1'b0, 1'b0, "R9 oldest evicted after hole");
    req(1'b1, SC, 32'h1010, 0, 1, 1'b1, 1'b1, "R9 second kept after hole");
    req(1'b1, SC, 32'h2000, 2, 0, 1'b1, 1'b1, "R9 hole entry present");
    req(1'b1, ST, 32'h1070, 3, 3, 1'b1, 1'b0, "R6 store with full table");

    @(negedge clk);
    req_valid = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule